// File: doc/BRIEF.md
# CEC receive bit timing decoder

This block decodes the receive side of a consumer-electronics-control style single-wire bus. The open-drain line is brought into the core clock domain through a two-flop synchronizer and is looked at only on a slow reference tick of about 32.768 kHz. Every falling edge seen on a tick starts a bit cycle. A tick counter measures the time since that edge and samples the line at a programmable decision point: a high level there is a logical 1 and a low level is a logical 0. The same counter catches bit cycles that last too long and, in suspend mode, silences that last several bit cycles.

Bits are grouped ten to a byte: eight data bits sent most significant first, then an end-of-message bit, then an acknowledge bit. The destination address is taken from the first byte of a frame. Frames for another device can be dropped or let through. Frames sent to everyone are always let through. For frames sent to its own address the block drives the acknowledge slot low. In suspend mode an error does not interrupt at once. The block keeps receiving, gives an inverted acknowledge, or declares a timeout if the bits stop, and then reports the event with a single pulse.

Top module: `cec_rx`

## Requirements
- R1: The bit value is the synchronized line level on the tick that comes SP ticks after the tick that saw the falling edge, where SP = 34 + offset. The 3-bit sample code maps to offsets as follows: 000 +0, 001 +2, 010 +4, 011 +6, 101 −2, 110 −4, 111 −6, and the reserved code 100 +0. Each sample gives a one-cycle bit_valid_o pulse with bit_o.
- R2: The maximum bit length is ML = 90 + (3-bit two's-complement code, −4..+3) ticks. With suspend off, if no new falling edge has come by tick ML+1 after the last one, err_irq_o pulses once and the receiver returns to idle.
- R3: A byte is 8 data bits, MSB first, followed by an end-of-message (EOM) bit and an acknowledge bit. When the EOM bit is sampled in an accepted frame, byte_valid_o pulses with byte_o and eom_o. After the acknowledge bit of a byte with EOM = 1 the receiver is idle, and later silence raises no error.
- R4: The destination is the low 4 bits of the first byte. A frame is accepted if the destination equals cfg_addr_i, if cfg_promisc_i is 1, or if the destination is 4'hF (broadcast). A rejected frame gives no byte_valid_o and no acknowledge drive.
- R5: In an accepted frame whose destination equals cfg_addr_i and is not 4'hF, ack_drive_o is high from the acknowledge bit's falling-edge tick until its sample tick, which is SP ticks. In broadcast frames and in frames let through by cfg_promisc_i it stays low.
- R6: With cfg_suspend_i = 1, a bit that runs too long raises no err_irq_o and reception goes on. At the acknowledge bit the drive decision of R5 is inverted. susp_irq_o then pulses once after that acknowledge sample, and the receiver goes idle.
- R7: With cfg_suspend_i = 1 and a too-long bit pending, if no falling edge comes, tmo_irq_o pulses once on tick (N+1)·ML+1 after the last edge. The 2-bit timeout code sets N: 00 → 1, 01 → 2, 10 → 3, and the reserved 11 → 3.
- R8: While rx_en_i is 0 the receiver is held idle: rx_idle_o is 1, and line edges produce no bits and no acknowledge drive.
- R9: After reset rx_idle_o is 1 and every pulse output and ack_drive_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| fs_tick_i | input | 1 | one-cycle reference tick (about 32.768 kHz) |
| rx_en_i | input | 1 | receive enable |
| line_i | input | 1 | raw bus line level |
| cfg_sample_i | input | 3 | decision point code |
| cfg_maxlen_i | input | 3 | signed maximum bit length adjust |
| cfg_timeout_i | input | 2 | timeout length in bit cycles |
| cfg_suspend_i | input | 1 | defer error interrupts |
| cfg_promisc_i | input | 1 | accept frames for other addresses |
| cfg_addr_i | input | 4 | own logical address |
| rx_idle_o | output | 1 | receiver idle (stopped) |
| bit_valid_o | output | 1 | bit sampled pulse |
| bit_o | output | 1 | sampled bit value |
| byte_valid_o | output | 1 | byte complete pulse |
| byte_o | output | 8 | received byte |
| eom_o | output | 1 | end-of-message flag of byte_o |
| ack_drive_o | output | 1 | pull the line low for acknowledge |
| err_irq_o | output | 1 | immediate bit-length error pulse |
| tmo_irq_o | output | 1 | suspended timeout pulse |
| susp_irq_o | output | 1 | suspended error reported after acknowledge |

## Verification
A table sweeps the decision point and the bit-length limit in pairs. The low period of each bit is placed right at or next to the decision point, so a design that is one tick off, or that misreads the negative codes or the reserved code, returns the wrong bit or raises the error one tick early or late. Directed frames test direct, mismatched, promiscuous and broadcast addressing. A filter that ignores the broadcast address, or an acknowledge that is driven too long or for the wrong frames, shows up in the byte count and in the number of ticks the acknowledge is driven. The suspend cases put one overlong bit into a frame and then stop the bus for two timeout codes. A design that interrupts at once, fails to invert the acknowledge, or counts silence from the wrong point fails on the pulse counts or the tick on which the timeout comes.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic {ST_IDLE, ST_ACTV} rx_state_e;

  // decision point offset in ticks, reserved code -> 0
  function automatic int sp_offset(input logic [2:0] code);
    case (code)
      3'b000:  return 0;
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 6;
      3'b101:  return -2;
      3'b110:  return -4;
      3'b111:  return -6;
      default: return 0;
    endcase
  endfunction

  // bit cycles of silence before timeout, reserved code -> 3
  function automatic int tmo_cycles(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/cec_rx_sync.sv
module cec_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (tick_i) prev_q <= sync_q[1];
    end
  end

  assign line_s_o = sync_q[1];
  assign fall_o   = tick_i & prev_q & ~sync_q[1];
endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer
  import cec_rx_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int SP_BASE = 34,
  parameter int ML_BASE = 90
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fall_i,
  input  logic [2:0] cfg_sample_i,
  input  logic [2:0] cfg_maxlen_i,
  input  logic [1:0] cfg_timeout_i,
  output logic       smp_at_o,
  output logic       ml_at_o,
  output logic       tmo_at_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sp_m1, ml_v, tmo_v;

  always_comb begin
    int sp_i;
    int ml_i;
    sp_i  = SP_BASE + sp_offset(cfg_sample_i) - 1;
    ml_i  = ML_BASE + int'($signed(cfg_maxlen_i));
    sp_m1 = CNT_W'(sp_i);
    ml_v  = CNT_W'(ml_i);
    tmo_v = CNT_W'(ml_i * (tmo_cycles(cfg_timeout_i) + 1));
  end

  // ticks since the last falling edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (tick_i) begin
      if (fall_i) cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign smp_at_o = (cnt_q == sp_m1);
  assign ml_at_o  = (cnt_q == ml_v);
  assign tmo_at_o = (cnt_q == tmo_v);
endmodule

// File: rtl/cec_rx_frame.sv
module cec_rx_frame
  import cec_rx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              line_s_i,
  input  logic              fall_i,
  input  logic              smp_at_i,
  input  logic              ml_at_i,
  input  logic              tmo_at_i,
  input  logic              cfg_suspend_i,
  input  logic              cfg_promisc_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  output logic              rx_idle_o,
  output logic              bit_valid_o,
  output logic              bit_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              eom_o,
  output logic              ack_drive_o,
  output logic              err_irq_o,
  output logic              tmo_irq_o,
  output logic              susp_irq_o
);
  localparam int BITS_PER_BYTE = BYTE_W + 2;
  localparam int IDX_W   = $clog2(BITS_PER_BYTE);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_EOM  = IDX_W'(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_ACK  = IDX_W'(BYTE_W + 1);
  localparam logic [ADDR_W-1:0] BCAST   = '1;

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              started_q, first_q, accept_q, direct_q, pend_q, eom_bit_q;
  logic              bitv_q, bit_q, bytev_q, eom_q, err_q, tmo_q, susp_q;
  logic [BYTE_W-1:0] byte_q;
  logic [ADDR_W-1:0] dst;

  assign dst = {shreg_q[ADDR_W-2:0], line_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      shreg_q   <= '0;
      started_q <= 1'b0;
      first_q   <= 1'b0;
      accept_q  <= 1'b0;
      direct_q  <= 1'b0;
      pend_q    <= 1'b0;
      eom_bit_q <= 1'b0;
      bitv_q    <= 1'b0;
      bit_q     <= 1'b0;
      bytev_q   <= 1'b0;
      byte_q    <= '0;
      eom_q     <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
      susp_q    <= 1'b0;
    end else begin
      bitv_q  <= 1'b0;
      bytev_q <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      susp_q  <= 1'b0;
      if (!rx_en_i) begin
        state_q   <= ST_IDLE;
        started_q <= 1'b0;
        pend_q    <= 1'b0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (fall_i) begin
            state_q   <= ST_ACTV;
            idx_q     <= '0;
            started_q <= 1'b1;
            first_q   <= 1'b1;
            accept_q  <= 1'b0;
            direct_q  <= 1'b0;
            pend_q    <= 1'b0;
          end
        end else begin
          if (fall_i) started_q <= 1'b1;
          if (ml_at_i && !pend_q) begin
            if (cfg_suspend_i) begin
              pend_q <= 1'b1;
            end else begin
              err_q     <= 1'b1;
              state_q   <= ST_IDLE;
              started_q <= 1'b0;
            end
          end else if (tmo_at_i && pend_q) begin
            tmo_q     <= 1'b1;
            state_q   <= ST_IDLE;
            started_q <= 1'b0;
            pend_q    <= 1'b0;
          end else if (smp_at_i && started_q && !fall_i) begin
            bitv_q    <= 1'b1;
            bit_q     <= line_s_i;
            started_q <= 1'b0;
            if (idx_q < IDX_EOM) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], line_s_i};
              idx_q   <= idx_q + 1'b1;
              if (idx_q == IDX_LAST && first_q) begin
                direct_q <= (dst == cfg_addr_i) && (dst != BCAST);
                accept_q <= (dst == cfg_addr_i) || (dst == BCAST) || cfg_promisc_i;
              end
            end else if (idx_q == IDX_EOM) begin
              eom_bit_q <= line_s_i;
              idx_q     <= IDX_ACK;
              if (accept_q) begin
                bytev_q <= 1'b1;
                byte_q  <= shreg_q;
                eom_q   <= line_s_i;
              end
            end else begin
              if (pend_q) begin
                susp_q  <= 1'b1;
                pend_q  <= 1'b0;
                state_q <= ST_IDLE;
              end else if (eom_bit_q) begin
                state_q <= ST_IDLE;
              end else begin
                idx_q   <= '0;
                first_q <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  assign rx_idle_o    = (state_q == ST_IDLE);
  assign ack_drive_o  = rx_en_i && (state_q == ST_ACTV) && (idx_q == IDX_ACK) &&
                        started_q && accept_q && (direct_q ^ pend_q);
  assign bit_valid_o  = bitv_q;
  assign bit_o        = bit_q;
  assign byte_valid_o = bytev_q;
  assign byte_o       = byte_q;
  assign eom_o        = eom_q;
  assign err_irq_o    = err_q;
  assign tmo_irq_o    = tmo_q;
  assign susp_irq_o   = susp_q;
endmodule

// File: rtl/cec_rx.sv
module cec_rx #(
  parameter int ADDR_W  = 4,
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 9,
  parameter int SP_BASE = 34,
  parameter int ML_BASE = 90
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_tick_i,
  input  logic              rx_en_i,
  input  logic              line_i,
  input  logic [2:0]        cfg_sample_i,
  input  logic [2:0]        cfg_maxlen_i,
  input  logic [1:0]        cfg_timeout_i,
  input  logic              cfg_suspend_i,
  input  logic              cfg_promisc_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  output logic              rx_idle_o,
  output logic              bit_valid_o,
  output logic              bit_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              eom_o,
  output logic              ack_drive_o,
  output logic              err_irq_o,
  output logic              tmo_irq_o,
  output logic              susp_irq_o
);
  logic line_s, fall, smp_at, ml_at, tmo_at;

  cec_rx_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (fs_tick_i),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  cec_rx_timer #(
    .CNT_W   (CNT_W),
    .SP_BASE (SP_BASE),
    .ML_BASE (ML_BASE)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (fs_tick_i),
    .fall_i        (fall),
    .cfg_sample_i  (cfg_sample_i),
    .cfg_maxlen_i  (cfg_maxlen_i),
    .cfg_timeout_i (cfg_timeout_i),
    .smp_at_o      (smp_at),
    .ml_at_o       (ml_at),
    .tmo_at_o      (tmo_at)
  );

  cec_rx_frame #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (fs_tick_i),
    .rx_en_i       (rx_en_i),
    .line_s_i      (line_s),
    .fall_i        (fall),
    .smp_at_i      (smp_at),
    .ml_at_i       (ml_at),
    .tmo_at_i      (tmo_at),
    .cfg_suspend_i (cfg_suspend_i),
    .cfg_promisc_i (cfg_promisc_i),
    .cfg_addr_i    (cfg_addr_i),
    .rx_idle_o     (rx_idle_o),
    .bit_valid_o   (bit_valid_o),
    .bit_o         (bit_o),
    .byte_valid_o  (byte_valid_o),
    .byte_o        (byte_o),
    .eom_o         (eom_o),
    .ack_drive_o   (ack_drive_o),
    .err_irq_o     (err_irq_o),
    .tmo_irq_o     (tmo_irq_o),
    .susp_irq_o    (susp_irq_o)
  );
endmodule

// File: rtl/cec_rx_chk.sv
module cec_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fs_tick_i,
  input logic rx_en_i,
  input logic cfg_suspend_i,
  input logic rx_idle_o,
  input logic bit_valid_o,
  input logic byte_valid_o,
  input logic ack_drive_o,
  input logic err_irq_o,
  input logic tmo_irq_o,
  input logic susp_irq_o
);
  p_bit_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(fs_tick_i));

  p_err_no_susp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> !cfg_suspend_i);

  p_err_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> rx_idle_o);

  p_byte_with_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> bit_valid_o);

  p_ack_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_drive_o) |-> $past(fs_tick_i));

  p_susp_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_irq_o |-> cfg_suspend_i && rx_idle_o);

  p_one_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_irq_o, tmo_irq_o, susp_irq_o}));

  p_tmo_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_irq_o |-> cfg_suspend_i && rx_idle_o);

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !bit_valid_o && !ack_drive_o);
endmodule

bind cec_rx cec_rx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fs_tick_i     (fs_tick_i),
  .rx_en_i       (rx_en_i),
  .cfg_suspend_i (cfg_suspend_i),
  .rx_idle_o     (rx_idle_o),
  .bit_valid_o   (bit_valid_o),
  .byte_valid_o  (byte_valid_o),
  .ack_drive_o   (ack_drive_o),
  .err_irq_o     (err_irq_o),
  .tmo_irq_o     (tmo_irq_o),
  .susp_irq_o    (susp_irq_o)
);

// File: tb/sim_cec_rx.sv
module sim_cec_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fs_tick_i = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       line_i = 1'b1;
  logic [2:0] cfg_sample_i = 3'b000;
  logic [2:0] cfg_maxlen_i = 3'b000;
  logic [1:0] cfg_timeout_i = 2'b00;
  logic       cfg_suspend_i = 1'b0;
  logic       cfg_promisc_i = 1'b0;
  logic [3:0] cfg_addr_i = 4'h4;
  logic       rx_idle_o, bit_valid_o, bit_o, byte_valid_o, eom_o;
  logic       ack_drive_o, err_irq_o, tmo_irq_o, susp_irq_o;
  logic [7:0] byte_o;

  cec_rx u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int tick_k, n_bits, n_bytes, n_err, n_tmo, n_susp, ack_ticks, err_at, tmo_at;
  logic first_bit;
  logic [7:0] byte_log [4];
  logic       eom_log [4];

  // {sample code, maxlen code, low ticks, expected bit, expected error tick}
  localparam logic [22:0] VEC [7] = '{
    {3'b000, 3'b000, 7'd36, 1'b0, 9'd91},
    {3'b001, 3'b011, 7'd36, 1'b1, 9'd94},
    {3'b011, 3'b100, 7'd40, 1'b1, 9'd87},
    {3'b101, 3'b111, 7'd36, 1'b0, 9'd90},
    {3'b111, 3'b001, 7'd28, 1'b1, 9'd92},
    {3'b110, 3'b010, 7'd31, 1'b0, 9'd93},
    {3'b100, 3'b101, 7'd34, 1'b1, 9'd88}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    tick_k = 0; n_bits = 0; n_bytes = 0; n_err = 0; n_tmo = 0; n_susp = 0;
    ack_ticks = 0; err_at = -1; tmo_at = -1; first_bit = 1'bx;
  endtask

  task automatic do_tick(input logic l);
    line_i = l;
    repeat (3) @(negedge clk_i);
    fs_tick_i = 1'b1;
    @(negedge clk_i);
    fs_tick_i = 1'b0;
    if (bit_valid_o) begin
      if (n_bits == 0) first_bit = bit_o;
      n_bits++;
    end
    if (byte_valid_o) begin
      if (n_bytes < 4) begin
        byte_log[n_bytes] = byte_o;
        eom_log[n_bytes]  = eom_o;
      end
      n_bytes++;
    end
    if (err_irq_o) begin
      if (n_err == 0) err_at = tick_k;
      n_err++;
    end
    if (tmo_irq_o) begin
      if (n_tmo == 0) tmo_at = tick_k;
      n_tmo++;
    end
    if (susp_irq_o) n_susp++;
    if (ack_drive_o) ack_ticks++;
    tick_k++;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b1);
  endtask

  task automatic send_bit(input logic b, input int p);
    int llow;
    llow = b ? 20 : 48;
    for (int i = 0; i < p; i++) do_tick((i < llow) ? 1'b0 : 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic eom, input int long_idx);
    for (int i = 0; i < 10; i++) begin
      logic b;
      b = (i < 8) ? d[7-i] : ((i == 8) ? eom : 1'b1);
      send_bit(b, (i == long_idx) ? 100 : 80);
    end
  endtask

  task automatic setup(input logic susp, input logic prom, input logic [1:0] tmo);
    rx_en_i = 1'b0;
    @(negedge clk_i);
    cfg_suspend_i = susp; cfg_promisc_i = prom; cfg_timeout_i = tmo;
    cfg_addr_i = 4'h4; cfg_sample_i = 3'b000; cfg_maxlen_i = 3'b000;
    rx_en_i = 1'b1;
    hold(3);
    clear_log();
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk("R9 idle", int'(rx_idle_o), 1);
    chk("R9 pulses", int'({bit_valid_o, byte_valid_o, err_irq_o, tmo_irq_o, susp_irq_o, ack_drive_o}), 0);

    // R1/R2 table sweep of decision point and maximum length
    for (int v = 0; v < 7; v++) begin
      logic [2:0] spc, mlc;
      logic [6:0] llow;
      logic       eb;
      logic [8:0] ek;
      {spc, mlc, llow, eb, ek} = VEC[v];
      setup(1'b0, 1'b0, 2'b00);
      rx_en_i = 1'b0;
      @(negedge clk_i);
      cfg_sample_i = spc; cfg_maxlen_i = mlc;
      rx_en_i = 1'b1;
      @(negedge clk_i);
      for (int i = 0; i < int'(ek) + 5; i++) do_tick((i < int'(llow)) ? 1'b0 : 1'b1);
      chk("R1 bit value", int'(first_bit), int'(eb));
      chk("R1 one sample", n_bits, 1);
      chk("R2 error tick", err_at, int'(ek));
      chk("R2 idle after error", int'(rx_idle_o), 1);
    end

    // R3/R5 direct frame
    setup(1'b0, 1'b0, 2'b00);
    send_byte(8'h34, 1'b0, -1);
    send_byte(8'hA5, 1'b1, -1);
    hold(150);
    chk("R3 bits", n_bits, 20);
    chk("R3 bytes", n_bytes, 2);
    chk("R3 header", int'(byte_log[0]), 8'h34);
    chk("R3 header eom", int'(eom_log[0]), 0);
    chk("R3 data", int'(byte_log[1]), 8'hA5);
    chk("R3 data eom", int'(eom_log[1]), 1);
    chk("R3 no error after eom", n_err, 0);
    chk("R3 idle", int'(rx_idle_o), 1);
    chk("R5 ack ticks direct", ack_ticks, 68);

    // R4 mismatch dropped
    setup(1'b0, 1'b0, 2'b00);
    send_byte(8'h13, 1'b0, -1);
    send_byte(8'h5A, 1'b1, -1);
    hold(20);
    chk("R4 mismatch bits", n_bits, 20);
    chk("R4 mismatch bytes", n_bytes, 0);
    chk("R4 mismatch ack", ack_ticks, 0);

    // R4/R5 promiscuous
    setup(1'b0, 1'b1, 2'b00);
    send_byte(8'h13, 1'b0, -1);
    send_byte(8'h5A, 1'b1, -1);
    hold(20);
    chk("R4 promisc bytes", n_bytes, 2);
    chk("R5 promisc ack", ack_ticks, 0);

    // R4/R5 broadcast with filter on
    setup(1'b0, 1'b0, 2'b00);
    send_byte(8'h1F, 1'b0, -1);
    send_byte(8'hC3, 1'b1, -1);
    hold(20);
    chk("R4 broadcast bytes", n_bytes, 2);
    chk("R4 broadcast data", int'(byte_log[1]), 8'hC3);
    chk("R5 broadcast ack", ack_ticks, 0);

    // R6 suspend, direct frame with one overlong bit
    setup(1'b1, 1'b0, 2'b00);
    send_byte(8'h34, 1'b1, 2);
    hold(20);
    chk("R6 no immediate error", n_err, 0);
    chk("R6 one deferred irq", n_susp, 1);
    chk("R6 inverted ack direct", ack_ticks, 0);
    chk("R6 byte kept", n_bytes, 1);
    chk("R6 idle", int'(rx_idle_o), 1);

    // R6 suspend, broadcast frame: inverted ack drives
    setup(1'b1, 1'b0, 2'b00);
    send_byte(8'h3F, 1'b1, 5);
    hold(20);
    chk("R6 inverted ack broadcast", ack_ticks, 34);
    chk("R6 one deferred irq bc", n_susp, 1);

    // R7 timeout, code 01 -> 2 bit cycles
    setup(1'b1, 1'b0, 2'b01);
    send_bit(1'b1, 300);
    chk("R7 timeout tick code 01", tmo_at, 271);
    chk("R7 single timeout", n_tmo, 1);
    chk("R7 no error pulse", n_err, 0);

    // R7 reserved code 11 -> 3 bit cycles
    setup(1'b1, 1'b0, 2'b11);
    send_bit(1'b0, 400);
    chk("R7 timeout tick code 11", tmo_at, 361);
    chk("R7 idle after timeout", int'(rx_idle_o), 1);

    // R8 disabled receiver
    setup(1'b0, 1'b0, 2'b00);
    rx_en_i = 1'b0;
    send_byte(8'h34, 1'b1, -1);
    chk("R8 no bits", n_bits, 0);
    chk("R8 no ack", ack_ticks, 0);
    chk("R8 idle", int'(rx_idle_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule